// File: doc/BRIEF.md
# Burst-splitting AXI4 memory writer

This block turns a write request and a packed byte stream into AXI4 write bursts. A configuration strobe loads a base address. Each request then gives a byte offset from that base and a total byte count. The data for the request arrives as a sequence of packets. Each packet carries up to one bus word of bytes, packed from lane 0 upward, with a valid byte count and a flag on the final packet.

The block computes the absolute start address and issues INCR bursts whose addresses are aligned down to the bus width. It splits the transfer wherever a burst would cross a 4 KiB page or exceed the maximum beat count. The byte stream is realigned onto the bus lanes, so that the byte for address A leaves on lane A mod (bus bytes). Bytes left over from one packet are carried into the next beat. The block waits for the write response of each burst and then returns a single status for the whole request. The status flags an error if any burst came back with a response other than OKAY.

Top module: `axi_burst_writer`

## Requirements
- R1: The first byte of a request goes to address base + offset. The base is the value of the most recent configuration strobe seen before the request was accepted.
- R2: Every AW transfer carries an address aligned down to the bus width, AWBURST = 2'b01 (INCR) and AWSIZE = log2(bus bytes). AW signals stay stable while AWVALID waits for AWREADY.
- R3: No burst crosses a 4096-byte address boundary.
- R4: No burst is longer than MAX_BEATS beats (AWLEN < MAX_BEATS). The bursts of a request are as long as these limits allow, in address order.
- R5: WSTRB bit i is set exactly for lane i of a beat whose byte address lies inside the request. This includes partial first and last beats. WDATA bytes in unstrobed lanes are zero. The byte for address A is placed on lane A mod (bus bytes).
- R6: Each burst carries AWLEN+1 beats, and WLAST is high on the final beat only.
- R7: Input packet sizes (1 to bus-bytes bytes, packed from lane 0) may be arbitrary. Bytes not fitting the current beat are carried forward. Packet bytes beyond the valid count are ignored.
- R8: Exactly one response is returned per request, after all write responses of its bursts. resp_err is 1 if any BRESP was not 2'b00, and otherwise 0. The response holds until taken.
- R9: A request of length zero issues no AW and no W transfer and returns resp_err = 0.
- R10: After reset the block is idle: req_ready = 1, and awvalid, wvalid, pkt_ready and resp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Load base address |
| cfg_base | input | ADDR_W | Base address value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high |
| req_offset | input | ADDR_W | Byte offset from base |
| req_len | input | LEN_W | Total bytes to write |
| pkt_valid | input | 1 | Data packet valid |
| pkt_ready | output | 1 | Data packet accepted when high |
| pkt_data | input | DATA_W | Packet bytes, first byte in lane 0 |
| pkt_bytes | input | log2(DATA_W/8)+1 | Valid bytes in the packet |
| pkt_last | input | 1 | Final packet of the request |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Beat size code |
| awburst | output | 2 | Burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes |
| wlast | output | 1 | Final beat of burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| resp_valid | output | 1 | Request status valid |
| resp_ready | input | 1 | Request status taken |
| resp_err | output | 1 | Request status: 1 = error |

## Verification
Requests are run with aligned and unaligned starts and ends, and with full-word packets as well as packets that shrink and grow in size. The size patterns separate a correct carry of leftover bytes from one that drops or duplicates bytes at packet edges. A request that starts a few bytes below a 4 KiB page, and a long one that needs several maximum-length bursts, tell the two splitting rules apart. An injected error response on a middle burst, a zero-length request and a base change check the status and address paths. Random stalls on AWREADY and WREADY are applied throughout.

// File: rtl/axi_burst_writer.sv
module axi_burst_writer #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BEATS = 16,
  parameter int BOUNDARY  = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_valid,
  input  logic [ADDR_W-1:0]             cfg_base,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_offset,
  input  logic [LEN_W-1:0]              req_len,
  input  logic                          pkt_valid,
  output logic                          pkt_ready,
  input  logic [DATA_W-1:0]             pkt_data,
  input  logic [$clog2(DATA_W/8):0]     pkt_bytes,
  input  logic                          pkt_last,
  output logic                          awvalid,
  input  logic                          awready,
  output logic [ADDR_W-1:0]             awaddr,
  output logic [7:0]                    awlen,
  output logic [2:0]                    awsize,
  output logic [1:0]                    awburst,
  output logic                          wvalid,
  input  logic                          wready,
  output logic [DATA_W-1:0]             wdata,
  output logic [DATA_W/8-1:0]           wstrb,
  output logic                          wlast,
  input  logic                          bvalid,
  output logic                          bready,
  input  logic [1:0]                    bresp,
  output logic                          resp_valid,
  input  logic                          resp_ready,
  output logic                          resp_err
);
  localparam int NB = DATA_W / 8;
  localparam int LB = $clog2(NB);
  localparam int BW = $clog2(BOUNDARY);
  localparam int CW = $clog2(2 * NB) + 1;

  typedef enum logic [2:0] {S_IDLE, S_AW, S_W, S_B, S_RESP} st_t;
  st_t st;

  logic [ADDR_W-1:0]   base_q, addr_q;
  logic [LEN_W-1:0]    rem_q, bleft_q;
  logic [LB-1:0]       lane_q;
  logic [2*DATA_W-1:0] acc_q, acc_n, pmask;
  logic [CW-1:0]       cnt_q, cnt_n, kept;
  logic                seen_last_q, err_q;

  wire [LB-1:0]     off     = addr_q[LB-1:0];
  wire [ADDR_W-1:0] aligned = {addr_q[ADDR_W-1:LB], {LB{1'b0}}};

  logic [31:0] tot_b, bnd_b, beats, room, bbytes;
  always_comb begin
    tot_b = (32'(rem_q) + 32'(off) + 32'(NB) - 32'd1) >> LB;
    bnd_b = (32'(BOUNDARY) - 32'(aligned[BW-1:0])) >> LB;
    beats = tot_b;
    if (bnd_b < beats) beats = bnd_b;
    if (32'(MAX_BEATS) < beats) beats = 32'(MAX_BEATS);
    room   = beats * 32'(NB) - 32'(off);
    bbytes = (32'(rem_q) < room) ? 32'(rem_q) : room;
  end

  logic [LB:0] need;
  always_comb begin
    if (32'(bleft_q) < 32'(NB) - 32'(lane_q)) need = (LB+1)'(bleft_q);
    else                                      need = (LB+1)'(32'(NB) - 32'(lane_q));
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      int lo, idx;
      lo  = int'(lane_q);
      idx = (i >= lo) ? i - lo : 0;
      wstrb[i] = (i >= lo) && (i < lo + int'(need));
      wdata[8*i +: 8] = wstrb[i] ? acc_q[8*idx +: 8] : 8'h00;
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign awvalid    = (st == S_AW);
  assign awaddr     = aligned;
  assign awlen      = 8'(beats - 32'd1);
  assign awsize     = 3'(LB);
  assign awburst    = 2'b01;
  assign wvalid     = (st == S_W) && (cnt_q >= CW'(need));
  assign wlast      = (LEN_W'(need) == bleft_q);
  assign bready     = (st == S_B);
  assign resp_valid = (st == S_RESP);
  assign resp_err   = err_q;
  assign pkt_ready  = (st == S_AW || st == S_W || st == S_B) && !seen_last_q
                      && (cnt_q <= CW'(NB));

  wire wfire = wvalid && wready;
  wire pfire = pkt_valid && pkt_ready;

  always_comb begin
    pmask = '0;
    for (int i = 0; i < NB; i++)
      pmask[8*i +: 8] = (i < int'(pkt_bytes)) ? pkt_data[8*i +: 8] : 8'h00;
    kept  = cnt_q - (wfire ? CW'(need) : CW'(0));
    acc_n = acc_q >> (8 * (wfire ? int'(need) : 0));
    cnt_n = kept;
    if (pfire) begin
      acc_n = acc_n | (pmask << (8 * int'(kept)));
      cnt_n = kept + CW'(pkt_bytes);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      base_q      <= '0;
      addr_q      <= '0;
      rem_q       <= '0;
      bleft_q     <= '0;
      lane_q      <= '0;
      acc_q       <= '0;
      cnt_q       <= '0;
      seen_last_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (cfg_valid) base_q <= cfg_base;
      acc_q <= acc_n;
      cnt_q <= cnt_n;
      if (pfire && pkt_last) seen_last_q <= 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q      <= base_q + req_offset;
          rem_q       <= req_len;
          err_q       <= 1'b0;
          seen_last_q <= 1'b0;
          acc_q       <= '0;
          cnt_q       <= '0;
          st          <= (req_len == '0) ? S_RESP : S_AW;
        end
        S_AW: if (awready) begin
          addr_q  <= addr_q + ADDR_W'(bbytes);
          rem_q   <= rem_q - LEN_W'(bbytes);
          bleft_q <= LEN_W'(bbytes);
          lane_q  <= off;
          st      <= S_W;
        end
        S_W: if (wfire) begin
          bleft_q <= bleft_q - LEN_W'(need);
          lane_q  <= '0;
          if (wlast) st <= S_B;
        end
        S_B: if (bvalid) begin
          if (bresp != 2'b00) err_q <= 1'b1;
          st <= (rem_q == '0) ? S_RESP : S_AW;
        end
        S_RESP: if (resp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));
  // R3
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (32'(awaddr[BW-1:0]) + (32'(awlen) + 32'd1) * 32'(NB)) <= 32'(BOUNDARY));
  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> 32'(awlen) < 32'(MAX_BEATS));
  // R5
  strb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> wstrb != '0);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(2 * NB));
  // R8
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_err));
endmodule

// File: tb/axi_burst_writer_test.sv
module axi_burst_writer_test;
  localparam int NB = 4;
  localparam int MAXB = 16;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cfg_valid = 0; logic [31:0] cfg_base = 0;
  logic req_valid = 0, req_ready; logic [31:0] req_offset = 0; logic [15:0] req_len = 0;
  logic pkt_valid = 0, pkt_ready, pkt_last = 0; logic [31:0] pkt_data = 0; logic [2:0] pkt_bytes = 0;
  logic awvalid, awready = 0; logic [31:0] awaddr; logic [7:0] awlen; logic [2:0] awsize; logic [1:0] awburst;
  logic wvalid, wready = 0, wlast; logic [31:0] wdata; logic [3:0] wstrb;
  logic bvalid = 0, bready; logic [1:0] bresp = 0;
  logic resp_valid, resp_ready = 1, resp_err;

  axi_burst_writer uut (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [31:0] q_aw_addr[$]; logic [7:0] q_aw_len[$];
  logic [31:0] q_wd[$]; logic [3:0] q_ws[$]; logic q_wl[$];
  logic [7:0] strm [0:1023];
  longint cur_base = 0;
  int err_burst = -1, bidx = 0, pend = 0, n_resp = 0;
  bit last_err;

  always @(posedge clk) begin
    awready <= ($urandom % 4) != 0;
    wready  <= ($urandom % 3) != 0;
    if (bvalid && bready) begin
      bvalid <= 0;
      bidx <= bidx + 1;
    end else if (!bvalid && pend > 0) begin
      bvalid <= 1;
      bresp  <= (bidx == err_burst) ? 2'b10 : 2'b00;
      pend   <= pend - 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (awvalid && awready) begin
      if (q_aw_addr.size() == 0) chk(0, "R9 unexpected AW", awaddr, 0);
      else begin
        logic [31:0] ea; logic [7:0] el;
        ea = q_aw_addr.pop_front(); el = q_aw_len.pop_front();
        chk(awaddr == ea, "R1/R3 awaddr", awaddr, ea);
        chk(awlen == el, "R4 awlen", awlen, el);
        chk(awburst == 2'b01 && awsize == 3'd2, "R2 awburst/awsize", {awburst, awsize}, 5'b01010);
      end
    end
    if (wvalid && wready) begin
      if (wlast) pend = pend + 1;
      if (q_wd.size() == 0) chk(0, "R9 unexpected W", wdata, 0);
      else begin
        logic [31:0] ed; logic [3:0] es; logic el;
        ed = q_wd.pop_front(); es = q_ws.pop_front(); el = q_wl.pop_front();
        chk(wstrb == es, "R5 wstrb", wstrb, es);
        chk(wdata == ed, "R5/R7 wdata", wdata, ed);
        chk(wlast == el, "R6 wlast", wlast, el);
      end
    end
    if (resp_valid && resp_ready) begin
      n_resp++;
      last_err = resp_err;
    end
  end

  task automatic build_model(input longint start, input int len);
    longint a = start; int rem = len;
    while (rem > 0) begin
      longint al = a & ~longint'(NB - 1);
      int o = int'(a - al);
      int tot = (o + rem + NB - 1) / NB;
      int bnd = int'((4096 - (al % 4096)) / NB);
      int bt = tot, bb;
      if (bnd < bt) bt = bnd;
      if (MAXB < bt) bt = MAXB;
      bb = (rem < bt * NB - o) ? rem : bt * NB - o;
      q_aw_addr.push_back(32'(al)); q_aw_len.push_back(8'(bt - 1));
      for (int i = 0; i < bt; i++) begin
        logic [31:0] d = 0; logic [3:0] s = 0;
        for (int l = 0; l < NB; l++) begin
          longint ad = al + i * NB + l;
          if (ad >= a && ad < a + bb) begin
            s[l] = 1; d[8*l +: 8] = strm[int'(ad - start)];
          end
        end
        q_wd.push_back(d); q_ws.push_back(s); q_wl.push_back(i == bt - 1);
      end
      a += bb; rem -= bb;
    end
  endtask

  task automatic set_base(input longint b);
    @(negedge clk); cfg_valid = 1; cfg_base = 32'(b);
    @(negedge clk); cfg_valid = 0;
    cur_base = b;
  endtask

  task automatic run_req(input longint off, input int len, input int mode, input int errb, input bit exp_err);
    for (int k = 0; k < len; k++) strm[k] = 8'(k * 13 + off + 5);
    build_model(cur_base + off, len);
    err_burst = errb; bidx = 0; n_resp = 0;
    fork
      begin
        @(negedge clk); req_valid = 1; req_offset = 32'(off); req_len = 16'(len);
        while (!req_ready) @(negedge clk);
        @(negedge clk); req_valid = 0;
      end
      begin
        int k = 0, pi = 0;
        @(negedge clk);
        while (k < len) begin
          int sz = (mode == 0) ? NB : (mode == 1) ? (pi % NB) + 1 : ((pi * 3) % NB) + 1;
          if (sz > len - k) sz = len - k;
          pkt_data = 32'hEEEEEEEE;
          for (int b = 0; b < sz; b++) pkt_data[8*b +: 8] = strm[k + b];
          pkt_bytes = 3'(sz); pkt_last = (k + sz == len); pkt_valid = 1;
          while (!pkt_ready) @(negedge clk);
          @(negedge clk);
          k += sz; pi++;
        end
        pkt_valid = 0; pkt_last = 0;
      end
      begin
        int t = 0;
        @(negedge clk);
        while (n_resp == 0 && t < 5000) begin @(negedge clk); t++; end
        chk(t < 5000, "R8 response timeout", t, 0);
        repeat (3) @(negedge clk);
      end
    join
    chk(n_resp == 1, "R8 one response", n_resp, 1);
    chk(last_err == exp_err, "R8 resp_err", last_err, exp_err);
    chk(q_aw_addr.size() == 0, "R4/R3 all bursts issued", q_aw_addr.size(), 0);
    chk(q_wd.size() == 0, "R6 all beats sent", q_wd.size(), 0);
    q_aw_addr.delete(); q_aw_len.delete(); q_wd.delete(); q_ws.delete(); q_wl.delete();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R10 req_ready", req_ready, 1);
    chk({awvalid, wvalid, pkt_ready, resp_valid} == 0, "R10 idle outputs",
        {awvalid, wvalid, pkt_ready, resp_valid}, 0);
    set_base(32'h1000);
    run_req(0, 16, 0, -1, 0);            // aligned, full words
    run_req(3, 13, 1, -1, 0);            // R5 partial lanes, R7 growing packets
    run_req(6, 23, 2, -1, 0);            // R7 mixed packet sizes
    run_req(32'hFF5, 40, 1, -1, 0);      // R3 4 KiB crossing
    run_req(32'h100, 150, 0, -1, 0);     // R4 max-length bursts
    run_req(2, 100, 2, 1, 1);            // R8 error on second burst
    run_req(9, 0, 0, -1, 0);             // R9 zero length
    set_base(32'h3000);
    run_req(32'h11, 37, 1, -1, 0);       // R1 new base
    run_req(32'hFFE, 70, 2, 0, 1);       // R3 crossing plus R8 error on first burst
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule